// File: doc/BRIEF.md
# Median-Mode Automatic Gain Control Loop

This block closes the gain-control loop of one receive channel. On every valid output sample it takes an unsigned magnitude, compares it with a programmable threshold and updates a gain accumulator. The gain is held in units of 1/32 dB. The gain multiplier, the dB-to-linear mapping and the magnitude calculation sit outside this block.

Median mode adds or subtracts a fixed step, and only the sign of the error picks the direction. Settling time therefore does not depend on the signal level. At steady state the loop sits where as many samples fall above the threshold as below it, and it dithers by one step. Two step settings are available: a coarse one for acquisition at the start of a burst and a fine one for tracking. A select input chooses between them. Mean mode instead adds the signed error, arithmetically scaled down by a programmable shift.

In both modes the result is clamped between a programmable floor and ceiling. Setting the floor equal to the ceiling pins the gain, which turns the loop off.

Top module: `agc_gain_loop`

## Requirements
- R1: While `rst` is high at a rising clock edge, `gain` takes the value of `gain_max` after that edge.
- R2: With `sample_valid` low, `gain` keeps its value across the clock edge.
- R3: In median mode (`loop_mode`=0), a valid sample whose magnitude is below the threshold raises `gain` by the selected step, subject to the limits.
- R4: In median mode, a valid sample whose magnitude is above the threshold lowers `gain` by the selected step, subject to the limits.
- R5: In median mode, a valid sample whose magnitude equals the threshold leaves `gain` unchanged when the gain is within the limits.
- R6: `step_sel`=0 uses `step_acq` and `step_sel`=1 uses `step_trk`.
- R7: A step register value above 96 (3 dB) is applied as 96.
- R8: In mean mode (`loop_mode`=1), a valid sample adds (threshold − magnitude) arithmetically shifted right by `mean_shift`. The shift rounds toward minus infinity, so an error of −3 shifted by 3 gives −1.
- R9: Each update is clamped so that the stored gain lies in [`gain_min`, `gain_max`]. With `gain_min` = `gain_max`, every update yields that value.
- R10: In median mode, when the magnitude alternates around the threshold, `gain` dithers by exactly one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; loads `gain_max` |
| sample_valid | input | 1 | Strobe marking a new magnitude sample |
| magnitude | input | 16 | Unsigned sample magnitude |
| threshold | input | 16 | Unsigned target magnitude |
| step_acq | input | 12 | Acquisition step, 1/32 dB units |
| step_trk | input | 12 | Tracking step, 1/32 dB units |
| step_sel | input | 1 | 0: acquisition step, 1: tracking step |
| loop_mode | input | 1 | 0: median loop, 1: mean loop |
| mean_shift | input | 4 | Right shift applied to the error in mean mode |
| gain_min | input | 12 | Lower gain limit, 1/32 dB units |
| gain_max | input | 12 | Upper gain limit, 1/32 dB units |
| gain | output | 12 | Current gain, 1/32 dB units |

## Verification
Two cases are the hardest to reach from the ports. The first is a mean-mode update with a small negative error, where rounding toward minus infinity must produce −1 rather than 0. The second is an update that lands outside the limits from either side. The stimulus table drives the accumulator through a fixed history to reach both. A large mean-mode error pushes the gain to the ceiling and past the floor. An error of −3 with a shift of 3 tests the rounding. Directed steps then load oversized step registers and equal limits.

// File: rtl/agc_pkg.sv
package agc_pkg;
   typedef enum logic {
      LOOP_MEDIAN = 1'b0,
      LOOP_MEAN   = 1'b1
   } loop_mode_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/agc_step_gen.sv
module agc_step_gen
   import agc_pkg::*;
#(
   parameter int GAIN_W   = 12,
   parameter int MAG_W    = 16,
   parameter int SHIFT_W  = 4,
   parameter int STEP_MAX = 96,
   parameter int DELTA_W  = 19
) (
   input  logic [MAG_W-1:0]          magnitude,
   input  logic [MAG_W-1:0]          threshold,
   input  logic [GAIN_W-1:0]         step_acq,
   input  logic [GAIN_W-1:0]         step_trk,
   input  logic                      step_sel,
   input  loop_mode_e                mode,
   input  logic [SHIFT_W-1:0]        mean_shift,
   output logic signed [DELTA_W-1:0] delta
);
   localparam int PAD_W = DELTA_W - MAG_W;
   localparam int GPAD_W = DELTA_W - GAIN_W;
   localparam logic [GAIN_W-1:0] STEP_CAP = GAIN_W'(STEP_MAX);

   logic [GAIN_W-1:0]         step_raw;
   logic [GAIN_W-1:0]         step_lim;
   logic signed [DELTA_W-1:0] step_s;
   logic signed [DELTA_W-1:0] err_s;
   logic signed [DELTA_W-1:0] mean_delta;
   logic signed [DELTA_W-1:0] median_delta;

   assign step_raw = step_sel ? step_trk : step_acq;

   generate
      if (STEP_MAX < (2 ** GAIN_W) - 1) begin : g_step_clip
         assign step_lim = (step_raw > STEP_CAP) ? STEP_CAP : step_raw;
      end else begin : g_step_pass
         assign step_lim = step_raw;
      end
   endgenerate

   assign step_s = $signed({{GPAD_W{1'b0}}, step_lim});
   assign err_s  = $signed({{PAD_W{1'b0}}, threshold}) - $signed({{PAD_W{1'b0}}, magnitude});
   assign mean_delta = err_s >>> mean_shift;

   always_comb begin
      if (threshold > magnitude)      median_delta = step_s;
      else if (threshold < magnitude) median_delta = -step_s;
      else                            median_delta = '0;
   end

   assign delta = (mode == LOOP_MEAN) ? mean_delta : median_delta;

   always_comb begin
      if (!$isunknown({mode, delta}) && mode == LOOP_MEDIAN) begin
         AST_STEP_CAP: assert (delta <= DELTA_W'(STEP_MAX) && delta >= -DELTA_W'(STEP_MAX)); // R7
      end
   end
endmodule

// File: rtl/agc_gain_clamp.sv
module agc_gain_clamp #(
   parameter int GAIN_W  = 12,
   parameter int DELTA_W = 19
) (
   input  logic [GAIN_W-1:0]         gain_cur,
   input  logic signed [DELTA_W-1:0] delta,
   input  logic [GAIN_W-1:0]         gain_min,
   input  logic [GAIN_W-1:0]         gain_max,
   output logic [GAIN_W-1:0]         gain_next
);
   localparam int PAD_W = DELTA_W - GAIN_W;

   logic signed [DELTA_W-1:0] sum_s;
   logic signed [DELTA_W-1:0] lo_s;
   logic signed [DELTA_W-1:0] hi_s;

   assign sum_s = $signed({{PAD_W{1'b0}}, gain_cur}) + delta;
   assign lo_s  = $signed({{PAD_W{1'b0}}, gain_min});
   assign hi_s  = $signed({{PAD_W{1'b0}}, gain_max});

   always_comb begin
      if (sum_s > hi_s)      gain_next = gain_max;
      else if (sum_s < lo_s) gain_next = gain_min;
      else                   gain_next = sum_s[GAIN_W-1:0];
   end
endmodule

// File: rtl/agc_gain_loop.sv
module agc_gain_loop
   import agc_pkg::*;
#(
   parameter int GAIN_W   = 12,
   parameter int MAG_W    = 16,
   parameter int SHIFT_W  = 4,
   parameter int STEP_MAX = 96
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               sample_valid,
   input  logic [MAG_W-1:0]   magnitude,
   input  logic [MAG_W-1:0]   threshold,
   input  logic [GAIN_W-1:0]  step_acq,
   input  logic [GAIN_W-1:0]  step_trk,
   input  logic               step_sel,
   input  logic               loop_mode,
   input  logic [SHIFT_W-1:0] mean_shift,
   input  logic [GAIN_W-1:0]  gain_min,
   input  logic [GAIN_W-1:0]  gain_max,
   output logic [GAIN_W-1:0]  gain
);
   localparam int DELTA_W = max_int(GAIN_W, MAG_W + 1) + 2;

   generate
      if (GAIN_W < 4) begin : g_bad_gain_w
         $error("agc_gain_loop: GAIN_W must be at least 4");
      end
      if (MAG_W < 2) begin : g_bad_mag_w
         $error("agc_gain_loop: MAG_W must be at least 2");
      end
      if (SHIFT_W < 1) begin : g_bad_shift_w
         $error("agc_gain_loop: SHIFT_W must be at least 1");
      end
      if (STEP_MAX < 1 || STEP_MAX >= (2 ** GAIN_W)) begin : g_bad_step
         $error("agc_gain_loop: STEP_MAX out of range");
      end
   endgenerate

   loop_mode_e                mode;
   logic signed [DELTA_W-1:0] delta;
   logic [GAIN_W-1:0]         gain_q;
   logic [GAIN_W-1:0]         gain_next;

   assign mode = loop_mode_e'(loop_mode);

   agc_step_gen #(
      .GAIN_W(GAIN_W), .MAG_W(MAG_W), .SHIFT_W(SHIFT_W),
      .STEP_MAX(STEP_MAX), .DELTA_W(DELTA_W)
   ) u_step (
      .magnitude(magnitude), .threshold(threshold),
      .step_acq(step_acq), .step_trk(step_trk), .step_sel(step_sel),
      .mode(mode), .mean_shift(mean_shift), .delta(delta)
   );

   agc_gain_clamp #(.GAIN_W(GAIN_W), .DELTA_W(DELTA_W)) u_clamp (
      .gain_cur(gain_q), .delta(delta),
      .gain_min(gain_min), .gain_max(gain_max), .gain_next(gain_next)
   );

   always_ff @(posedge clk) begin
      if (rst)               gain_q <= gain_max;
      else if (sample_valid) gain_q <= gain_next;
   end

   assign gain = gain_q;

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !sample_valid |=> gain == $past(gain)); // R2

   AST_WITHIN_LIMITS: assert property (@(posedge clk) disable iff (rst)
      (sample_valid && gain_min <= gain_max)
      |=> (gain >= $past(gain_min) && gain <= $past(gain_max))); // R9

   AST_EQUAL_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (sample_valid && !loop_mode && magnitude == threshold
       && gain >= gain_min && gain <= gain_max)
      |=> gain == $past(gain)); // R5

   AST_BELOW_RAISES: assert property (@(posedge clk) disable iff (rst)
      (sample_valid && !loop_mode && magnitude < threshold
       && gain >= gain_min && gain <= gain_max)
      |=> gain >= $past(gain)); // R3

   AST_ABOVE_LOWERS: assert property (@(posedge clk) disable iff (rst)
      (sample_valid && !loop_mode && magnitude > threshold
       && gain >= gain_min && gain <= gain_max)
      |=> gain <= $past(gain)); // R4
endmodule

// File: tb/agc_gain_loop_test.sv
`timescale 1ns/1ps
module agc_gain_loop_test;
   typedef struct packed {
      logic        valid;
      logic        mode;
      logic        sel;
      logic [3:0]  shift;
      logic [15:0] mag;
      logic [15:0] thr;
      logic [11:0] exp;
      logic [3:0]  req;
   } vec_t;

   // Starting gain 3000, limits [100, 3000], step_acq 64, step_trk 8.
   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b0, 1'b0, 4'd0,  16'd500, 16'd1000, 12'd3000, 4'd9},  // R9 ceiling
      '{1'b1, 1'b0, 1'b0, 4'd0, 16'd2000, 16'd1000, 12'd2936, 4'd4},  // R4
      '{1'b1, 1'b0, 1'b1, 4'd0, 16'd2000, 16'd1000, 12'd2928, 4'd6},  // R6
      '{1'b1, 1'b0, 1'b0, 4'd0,  16'd500, 16'd1000, 12'd2992, 4'd3},  // R3
      '{1'b0, 1'b0, 1'b0, 4'd0,  16'd500, 16'd1000, 12'd2992, 4'd2},  // R2
      '{1'b1, 1'b0, 1'b0, 4'd0, 16'd1000, 16'd1000, 12'd2992, 4'd5},  // R5
      '{1'b1, 1'b1, 1'b0, 4'd2, 16'd1800, 16'd1000, 12'd2792, 4'd8},  // R8
      '{1'b1, 1'b1, 1'b0, 4'd3, 16'd1003, 16'd1000, 12'd2791, 4'd8},  // R8 floor
      '{1'b1, 1'b1, 1'b0, 4'd0,    16'd0, 16'd1000, 12'd3000, 4'd9},  // R9
      '{1'b1, 1'b1, 1'b0, 4'd0, 16'd4000, 16'd1000, 12'd100,  4'd9},  // R9 floor
      '{1'b1, 1'b0, 1'b1, 4'd0,  16'd500, 16'd1000, 12'd108,  4'd3},  // R3
      '{1'b1, 1'b0, 1'b1, 4'd0, 16'd2000, 16'd1000, 12'd100,  4'd4},  // R4
      '{1'b1, 1'b0, 1'b1, 4'd0,  16'd500, 16'd1000, 12'd108,  4'd10}, // R10
      '{1'b1, 1'b0, 1'b1, 4'd0,  16'd500, 16'd1000, 12'd116,  4'd10}, // R10
      '{1'b1, 1'b0, 1'b1, 4'd0, 16'd2000, 16'd1000, 12'd108,  4'd10}, // R10
      '{1'b1, 1'b0, 1'b1, 4'd0,  16'd500, 16'd1000, 12'd116,  4'd10}  // R10
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        sample_valid = 1'b0;
   logic [15:0] magnitude = '0;
   logic [15:0] threshold = '0;
   logic [11:0] step_acq = 12'd64;
   logic [11:0] step_trk = 12'd8;
   logic        step_sel = 1'b0;
   logic        loop_mode = 1'b0;
   logic [3:0]  mean_shift = '0;
   logic [11:0] gain_min = 12'd100;
   logic [11:0] gain_max = 12'd3000;
   logic [11:0] gain;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   agc_gain_loop uut (
      .clk(clk), .rst(rst), .sample_valid(sample_valid),
      .magnitude(magnitude), .threshold(threshold),
      .step_acq(step_acq), .step_trk(step_trk), .step_sel(step_sel),
      .loop_mode(loop_mode), .mean_shift(mean_shift),
      .gain_min(gain_min), .gain_max(gain_max), .gain(gain)
   );

   task automatic check(input int req, input logic [11:0] act, input logic [11:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d: gain=%0d expected %0d", req, act, exp);
      end
   endtask

   task automatic apply(input logic v, input logic m, input logic s, input logic [3:0] sh,
                        input logic [15:0] mg, input logic [15:0] th);
      sample_valid = v; loop_mode = m; step_sel = s; mean_shift = sh;
      magnitude = mg; threshold = th;
      @(negedge clk);
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      check(1, gain, 12'd3000); // R1 reset loads ceiling
      rst = 1'b0;
      @(negedge clk);
      check(2, gain, 12'd3000); // R2 idle after reset

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i].valid, VECS[i].mode, VECS[i].sel, VECS[i].shift,
               VECS[i].mag, VECS[i].thr);
         check(int'(VECS[i].req), gain, VECS[i].exp);
      end

      // R7: oversized steps act as 96
      step_acq = 12'd500;
      apply(1'b1, 1'b0, 1'b0, 4'd0, 16'd500, 16'd1000);
      check(7, gain, 12'd212);
      step_trk = 12'd2000;
      apply(1'b1, 1'b0, 1'b1, 4'd0, 16'd500, 16'd1000);
      check(7, gain, 12'd308);
      apply(1'b1, 1'b0, 1'b1, 4'd0, 16'd2000, 16'd1000);
      check(7, gain, 12'd212);

      // R9: equal limits freeze the gain
      gain_min = 12'd1500; gain_max = 12'd1500;
      apply(1'b1, 1'b0, 1'b0, 4'd0, 16'd500, 16'd1000);
      check(9, gain, 12'd1500);
      apply(1'b1, 1'b1, 1'b0, 4'd0, 16'd9000, 16'd1000);
      check(9, gain, 12'd1500);

      // R1: reset reloads the current ceiling
      gain_min = 12'd100; gain_max = 12'd2000;
      rst = 1'b1;
      apply(1'b1, 1'b0, 1'b0, 4'd0, 16'd500, 16'd1000);
      check(1, gain, 12'd2000);
      rst = 1'b0;
      apply(1'b0, 1'b0, 1'b0, 4'd0, 16'd500, 16'd1000);
      check(2, gain, 12'd2000);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule